// File: doc/BRIEF.md
# Aliased Four-Word Register Slave on AXI4-Lite

This block is a small AXI4-Lite slave that gives a 32-bit host access to four 32-bit storage words. It decodes a 32-byte window. The lower half of the window, offsets 0x00 through 0x0F, maps onto the four words. The upper half, offsets 0x10 through 0x1F, has no storage. A write there is acknowledged and discarded, and a read there returns zero. Only the low five address bits take part in decoding. Any wider address therefore folds onto the same 32 bytes. The byte-offset bits within a word select nothing, so all four byte addresses of a word reach the same register.

A write is taken only as a pair. The slave raises the ready signals of the write-address and write-data channels together. It does so only when both valids are high and no write response is still waiting. The write response follows in the next cycle. Reads are taken one at a time. The read data is registered in the cycle the request is accepted. Every response is OKAY.

Top module: `alias_reg_slave`

## Requirements
- R1: After reset, b_valid and r_valid are 0, ar_ready is 1, and all four storage words read as 0.
- R2: aw_ready and w_ready are always equal. Both are 1 only in a cycle in which aw_valid and w_valid are both 1. A lone address or lone data item is never taken and produces no response.
- R3: An accepted write raises b_valid in the next cycle, with b_resp = 2'b00 (OKAY).
- R4: b_valid stays 1 until a cycle with b_ready = 1. While b_valid is 1, no further write is accepted.
- R5: A write to offsets 0x00 to 0x0F updates the word selected by address bits [3:2]. Strobe bit i enables data bits [8i+7:8i], and lanes whose strobe is 0 keep their old value.
- R6: A write to offsets 0x10 to 0x1F (address bit 4 = 1) changes no storage word. A read there returns 0.
- R7: Address bits [1:0] do not affect decoding. A write or read at any byte address of a word reaches that whole word.
- R8: ar_ready is the inverse of r_valid. An accepted read raises r_valid in the next cycle with the addressed word and r_resp = 2'b00. r_valid and r_data hold until r_ready is 1.
- R9: When a read and a write to the same word are accepted in the same cycle, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_addr | input | 5 | Write address |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| w_data | input | 32 | Write data |
| w_strb | input | 4 | Write byte enables |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| b_resp | output | 2 | Write response, always OKAY |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| ar_addr | input | 5 | Read address |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| r_data | output | 32 | Read data |
| r_resp | output | 2 | Read response, always OKAY |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |

## Verification
A write into a storage word and a read from that same word can be accepted at the same clock edge, because the two paths are independent. The bench provokes this by presenting a paired write and a read of one word in the same cycle. It then judges the returned data against the word's old value. A follow-up read must return the new value. The other overlap covered is a stalled write response coinciding with a fresh write request. The bench judges this case by checking that aw_ready stays low until b_ready is given.

// File: rtl/alias_reg_pkg.sv
package alias_reg_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  // a window offset is backed when every bit above the word index is zero
  function automatic logic offset_backed(input logic [7:0] off, input int idx_top);
    logic hit;
    hit = 1'b1;
    for (int b = 0; b < 8; b++) begin
      if (b >= idx_top && off[b]) hit = 1'b0;
    end
    return hit;
  endfunction
endpackage

// File: rtl/alias_reg_bank.sv
module alias_reg_bank #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int WIN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WIN_W-1:0]    wr_off,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_strb,
  input  logic [WIN_W-1:0]    rd_off,
  output logic [DATA_W-1:0]   rd_word
);
  import alias_reg_pkg::*;

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_B = $clog2(LANES);
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int IDX_TOP = LANE_B + IDX_W;

  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [LANES-1:0]  en
  );
    logic [DATA_W-1:0] res;
    for (int l = 0; l < LANES; l++) begin
      res[l*8 +: 8] = en[l] ? new_v[l*8 +: 8] : old_v[l*8 +: 8];
    end
    return res;
  endfunction

  logic [DATA_W-1:0]          store [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] store_flat;
  logic                       wr_backed, rd_backed;
  logic [IDX_W-1:0]           wr_idx, rd_idx;

  assign wr_backed = offset_backed(8'(wr_off), IDX_TOP);
  assign rd_backed = offset_backed(8'(rd_off), IDX_TOP);
  assign wr_idx    = wr_off[LANE_B +: IDX_W];
  assign rd_idx    = rd_off[LANE_B +: IDX_W];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          store[g] <= '0;
        end else if (wr_en && wr_backed && (wr_idx == IDX_W'(g))) begin
          store[g] <= lane_merge(store[g], wr_data, wr_strb);
        end
      end
      assign store_flat[g*DATA_W +: DATA_W] = store[g];
    end
  endgenerate

  assign rd_word = rd_backed ? store[rd_idx] : '0;

  // R6: writes into the unbacked half leave every word untouched
  p_upper_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_backed) |=> $stable(store_flat));

  // R6: reads of the unbacked half see zero
  p_upper_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_backed |-> (rd_word == '0));
endmodule

// File: rtl/alias_wr_chan.sv
module alias_wr_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aw_valid,
  input  logic       w_valid,
  output logic       aw_ready,
  output logic       w_ready,
  output logic [1:0] b_resp,
  output logic       b_valid,
  input  logic       b_ready,
  output logic       wr_fire
);
  import alias_reg_pkg::*;

  logic pair_present;
  logic resp_pending;

  assign pair_present = aw_valid && w_valid;
  assign wr_fire      = pair_present && !resp_pending;
  assign aw_ready     = wr_fire;
  assign w_ready      = wr_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_pending <= 1'b0;
    end else if (wr_fire) begin
      resp_pending <= 1'b1;
    end else if (b_ready) begin
      resp_pending <= 1'b0;
    end
  end

  assign b_valid = resp_pending;
  assign b_resp  = RESP_OKAY;

  // R2: both readies move together and only with both valids present
  p_joint_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_ready || w_ready) |-> (aw_valid && w_valid && aw_ready && w_ready));

  // R3: accepted write yields a response next cycle
  p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (b_valid && b_resp == 2'b00));

  // R4: response held until taken
  p_resp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> b_valid);

  // R4: no new write while a response waits
  p_no_accept_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> !aw_ready);
endmodule

// File: rtl/alias_rd_chan.sv
module alias_rd_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_valid,
  input  logic              r_ready,
  output logic              rd_fire
);
  import alias_reg_pkg::*;

  logic              data_held;
  logic [DATA_W-1:0] data_q;

  assign ar_ready = !data_held;
  assign rd_fire  = ar_valid && ar_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_held <= 1'b0;
      data_q    <= '0;
    end else if (rd_fire) begin
      data_held <= 1'b1;
      data_q    <= rd_word;
    end else if (r_ready) begin
      data_held <= 1'b0;
    end
  end

  assign r_valid = data_held;
  assign r_data  = data_q;
  assign r_resp  = RESP_OKAY;

  // R8: data and valid held while stalled
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));

  // R8: accepted read yields data next cycle
  p_rdata_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (r_valid && r_resp == 2'b00));

  // R8: no second request taken while data waits
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !ar_ready);
endmodule

// File: rtl/alias_reg_slave.sv
module alias_reg_slave #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 4,
  parameter int WIN_BYTES = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic                aw_valid,
  output logic                aw_ready,
  input  logic [DATA_W-1:0]   w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_valid,
  output logic                w_ready,
  output logic [1:0]          b_resp,
  output logic                b_valid,
  input  logic                b_ready,
  input  logic [ADDR_W-1:0]   ar_addr,
  input  logic                ar_valid,
  output logic                ar_ready,
  output logic [DATA_W-1:0]   r_data,
  output logic [1:0]          r_resp,
  output logic                r_valid,
  input  logic                r_ready
);
  localparam int WIN_W = $clog2(WIN_BYTES);

  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_word;
  logic [WIN_W-1:0]  wr_off, rd_off;

  // only the window bits decode; everything above folds onto the window
  assign wr_off = aw_addr[WIN_W-1:0];
  assign rd_off = ar_addr[WIN_W-1:0];

  alias_wr_chan u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .aw_valid (aw_valid),
    .w_valid  (w_valid),
    .aw_ready (aw_ready),
    .w_ready  (w_ready),
    .b_resp   (b_resp),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .wr_fire  (wr_fire)
  );

  alias_reg_bank #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .WIN_W    (WIN_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_off  (wr_off),
    .wr_data (w_data),
    .wr_strb (w_strb),
    .rd_off  (rd_off),
    .rd_word (rd_word)
  );

  alias_rd_chan #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ar_valid (ar_valid),
    .ar_ready (ar_ready),
    .rd_word  (rd_word),
    .r_data   (r_data),
    .r_resp   (r_resp),
    .r_valid  (r_valid),
    .r_ready  (r_ready),
    .rd_fire  (rd_fire)
  );

  // R1: responses idle in the first cycle after reset release
  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!b_valid && !r_valid));

  // R9: a read taken with a write still reports a registered result next cycle
  p_overlap_both_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> (b_valid && r_valid));
endmodule

// File: tb/tb_alias_reg_slave.sv
module tb_alias_reg_slave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  aw_addr, ar_addr;
  logic        aw_valid, w_valid, b_ready, ar_valid, r_ready;
  logic [31:0] w_data;
  logic [3:0]  w_strb;
  logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
  logic [1:0]  b_resp, r_resp;
  logic [31:0] r_data;

  always #10 clk = ~clk;

  alias_reg_slave dut (
    .clk(clk), .rst_n(rst_n),
    .aw_addr(aw_addr), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_data(w_data), .w_strb(w_strb), .w_valid(w_valid), .w_ready(w_ready),
    .b_resp(b_resp), .b_valid(b_valid), .b_ready(b_ready),
    .ar_addr(ar_addr), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_data(r_data), .r_resp(r_resp), .r_valid(r_valid), .r_ready(r_ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [4];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model write: strobe bit i picks byte i; bit 4 of the offset means no storage
  function automatic void model_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    if (a[4] == 1'b0) begin
      for (int k = 0; k < 4; k++)
        if (s[k]) model[a[3:2]][k*8 +: 8] = d[k*8 +: 8];
    end
  endfunction

  function automatic logic [31:0] model_read(input logic [4:0] a);
    return a[4] ? 32'h0 : model[a[3:2]];
  endfunction

  // monitor: pops expected read data at each read handshake
  always @(posedge clk) begin
    if (rst_n && r_valid && r_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected read data", r_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(r_data == e && r_resp == 2'b00, t, r_data, e);
      end
    end
  end

  task automatic do_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s, input string tag);
    @(negedge clk);
    aw_addr = a; w_data = d; w_strb = s; aw_valid = 1'b1; w_valid = 1'b1;
    #1;
    chk(aw_ready && w_ready, {tag, " R2 pair ready"}, {30'b0, aw_ready, w_ready}, 32'h3);
    @(negedge clk);
    chk(b_valid && b_resp == 2'b00, {tag, " R3 response"}, {29'b0, b_valid, b_resp}, 32'h4);
    aw_valid = 1'b0; w_valid = 1'b0;
    model_write(a, d, s);
  endtask

  task automatic do_read(input logic [4:0] a, input string tag);
    @(negedge clk);
    while (!ar_ready) @(negedge clk);
    ar_addr = a; ar_valid = 1'b1;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    ar_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, "R8 reads drained", exp_q.size(), 0);
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog expired", 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = 32'h0;
    rst_n = 1'b0; aw_valid = 0; w_valid = 0; ar_valid = 0; b_ready = 1; r_ready = 1;
    aw_addr = 0; ar_addr = 0; w_data = 0; w_strb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!b_valid && !r_valid && ar_ready, "R1 idle after reset", {29'b0, b_valid, r_valid, ar_ready}, 32'h1);
    for (int k = 0; k < 4; k++) do_read(5'(k * 4), "R1 word zero after reset");
    drain();

    // R2 lone address / lone data not taken
    @(negedge clk);
    aw_addr = 5'h04; aw_valid = 1'b1; w_data = 32'hDEAD_BEEF; w_strb = 4'hF;
    #1 chk(!aw_ready && !w_ready, "R2 lone address", {30'b0, aw_ready, w_ready}, 0);
    @(negedge clk);
    aw_valid = 1'b0; w_valid = 1'b1;
    #1 chk(!aw_ready && !w_ready, "R2 lone data", {30'b0, aw_ready, w_ready}, 0);
    @(negedge clk);
    w_valid = 1'b0;
    chk(!b_valid, "R2 no response from lone halves", {31'b0, b_valid}, 0);
    do_read(5'h04, "R2 word unchanged by lone halves");
    drain();

    // R5 full and partial writes
    do_write(5'h00, 32'h1111_2222, 4'hF, "R5 w0");
    do_write(5'h08, 32'hA5A5_1234, 4'hF, "R5 w2");
    do_write(5'h08, 32'hFFFF_FFFF, 4'b0101, "R5 strobe");
    do_write(5'h0C, 32'h8765_4321, 4'b1000, "R5 top lane");
    for (int k = 0; k < 4; k++) do_read(5'(k * 4), "R5 readback");
    drain();

    // R7 byte offset bits ignored
    do_write(5'h05, 32'h0BAD_F00D, 4'hF, "R7 w1 at offset 5");
    do_read(5'h07, "R7 alias read offset 7");
    do_read(5'h0B, "R7 alias read offset 0xB");
    drain();

    // R6 upper half inert
    do_write(5'h14, 32'hCAFE_CAFE, 4'hF, "R6 upper write");
    do_write(5'h1F, 32'h1234_5678, 4'hF, "R6 upper write top");
    do_read(5'h14, "R6 upper reads zero");
    do_read(5'h04, "R6 word 1 untouched");
    do_read(5'h0C, "R6 word 3 untouched");
    drain();

    // R4 held response blocks a new write
    b_ready = 1'b0;
    do_write(5'h00, 32'h0000_00AA, 4'hF, "R4 first");
    @(negedge clk);
    aw_addr = 5'h00; w_data = 32'h0000_00BB; w_strb = 4'hF; aw_valid = 1; w_valid = 1;
    #1 chk(b_valid && !aw_ready, "R4 blocked while response waits", {30'b0, b_valid, aw_ready}, 32'h2);
    @(negedge clk);
    chk(b_valid, "R4 response held", {31'b0, b_valid}, 1);
    b_ready = 1'b1;
    @(negedge clk);
    #1 chk(aw_ready, "R4 accept after response taken", {31'b0, aw_ready}, 1);
    @(negedge clk);
    aw_valid = 0; w_valid = 0;
    model_write(5'h00, 32'h0000_00BB, 4'hF);
    do_read(5'h00, "R4 second write landed");
    drain();

    // R8 stalled read data holds
    r_ready = 1'b0;
    do_read(5'h08, "R8 stalled read");
    repeat (2) @(negedge clk);
    chk(r_valid && !ar_ready && r_data == model[2], "R8 held while stalled", r_data, model[2]);
    r_ready = 1'b1;
    drain();

    // R9 same-cycle read and write of one word
    @(negedge clk);
    aw_addr = 5'h04; w_data = 32'h5555_AAAA; w_strb = 4'hF; aw_valid = 1; w_valid = 1;
    ar_addr = 5'h04; ar_valid = 1;
    exp_q.push_back(model[1]);
    tag_q.push_back("R9 overlap read sees old value");
    @(negedge clk);
    aw_valid = 0; w_valid = 0; ar_valid = 0;
    chk(b_valid, "R9 write response", {31'b0, b_valid}, 1);
    model_write(5'h04, 32'h5555_AAAA, 4'hF);
    do_read(5'h04, "R9 later read sees new value");
    drain();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule